// File: doc/BRIEF.md
# Dual-Channel Converter Result Read Interface

This block is the digital front of a two-channel sampling converter. A start strobe taken while idle launches one conversion cycle: channel A converts for a fixed number of clocks, then channel B does. Each channel's result is captured from a stimulus port at the start of that channel's phase and moved into a per-channel output register when its phase ends. A host reads the results over a 16-bit parallel bus. It picks the channel with a select input and can exchange the two byte lanes, so an 8-bit host can fetch both bytes over one lane.

The sequencer has three named states. IDLE waits for a start. CONV_A counts the channel A phase. CONV_B counts the channel B phase. There are three transitions. LAUNCH goes from IDLE to CONV_A on a start strobe. HANDOFF goes from CONV_A to CONV_B when the A count expires. FINISH goes from CONV_B to IDLE when the B count expires. A serial-mode flag changes when channel A's register is loaded. In parallel mode it loads at HANDOFF, so A can be read while B is still converting. In serial mode it loads at FINISH. A flag marks reads that fall in the second half of a conversion phase, where reads should be avoided.

Top module: `dualconv_read_if`

## Requirements
- R1: After reset, busy is low, the active-low end-of-conversion output is high, the bus output enable and late-read flag are low, and both channel result registers read as zero.
- R2: A start strobe seen at a clock edge while idle raises busy after that edge. Busy then stays high for exactly A_CYC + B_CYC clocks.
- R3: A start strobe that arrives while busy is ignored. The cycle length and the results are unaffected, and no second cycle follows.
- R4: The end-of-conversion output goes low for exactly one clock after each channel's phase ends, giving two pulses per cycle. The second pulse coincides with the first idle clock.
- R5: The channel A result is the stimulus value present at the accepting start edge. The channel B result is the stimulus value present at the HANDOFF edge. Later changes of either stimulus do not alter them.
- R6: Channel select = 1 presents the channel A result; channel select = 0 presents channel B.
- R7: With byte swap = 0, result bits [7:0] drive data[7:0] and bits [15:8] drive data[15:8]. With byte swap = 1, bits [7:0] drive data[15:8] and bits [15:8] drive data[7:0].
- R8: The output enable is high only while chip select and read (both active low) are low together. Otherwise the output enable is low and data reads as zero.
- R9: In parallel mode (serial flag = 0), the new channel A result is readable from the clock after HANDOFF, while busy is still high.
- R10: In serial mode (serial flag = 1), channel A still reads the previous result after HANDOFF. The new result appears only after FINISH.
- R11: During a conversion cycle, channel B reads return the previous cycle's result until FINISH.
- R12: The late-read flag is high while a read is active, busy is high, and the phase counter (0 at the first clock of a phase) is at least half that phase's length (integer division). It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion start strobe |
| sample_a_i | input | 16 | Stimulus value for channel A |
| sample_b_i | input | 16 | Stimulus value for channel B |
| serial_mode_i | input | 1 | 1 = channel A register loads at FINISH |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read, active low |
| chan_sel_i | input | 1 | 1 = channel A, 0 = channel B |
| swap_i | input | 1 | Byte lane exchange |
| busy_o | output | 1 | Conversion cycle in progress |
| eoc_n_o | output | 1 | End-of-conversion pulse, active low |
| data_o | output | 16 | Bus data |
| data_oe_o | output | 1 | Bus drive enable |
| late_read_o | output | 1 | Read during second half of a phase |

## Verification
The hardest case to reach is the short window between HANDOFF and FINISH. In that window the two channel registers belong to different cycles, and the serial flag decides which one channel A reads. To get there, the bench counts clocks from the accepted start and reads channel A and channel B at the exact clock after HANDOFF. It changes both stimulus values right after their capture edges, so a capture at the wrong edge or a load under the wrong mode shows up as a wrong byte pattern.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_CONV_A = 2'd1,
        S_CONV_B = 2'd2
    } dcr_state_t;
endpackage

// File: rtl/dcr_seq.sv
module dcr_seq
    import dcr_pkg::*;
#(
    parameter int A_CYC = 8,
    parameter int B_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic launch_o,
    output logic done_a_o,
    output logic done_b_o,
    output logic busy_o,
    output logic eoc_n_o,
    output logic late_half_o
);
    localparam int MAX_CYC = (A_CYC > B_CYC) ? A_CYC : B_CYC;
    localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
    localparam logic [CNT_W-1:0] A_LAST = CNT_W'(A_CYC - 1);
    localparam logic [CNT_W-1:0] B_LAST = CNT_W'(B_CYC - 1);
    localparam logic [CNT_W-1:0] A_HALF = CNT_W'(A_CYC / 2);
    localparam logic [CNT_W-1:0] B_HALF = CNT_W'(B_CYC / 2);

    dcr_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // transition strobes: LAUNCH, HANDOFF, FINISH
    assign launch_o = (state_q == S_IDLE)   && start_i;
    assign done_a_o = (state_q == S_CONV_A) && (cnt_q == A_LAST);
    assign done_b_o = (state_q == S_CONV_B) && (cnt_q == B_LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (launch_o) state_d = S_CONV_A;
            S_CONV_A: if (done_a_o) state_d = S_CONV_B;
            S_CONV_B: if (done_b_o) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register and phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) cnt_q <= '0;
            else if (state_q != S_IDLE) cnt_q <= cnt_q + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eoc_n_o <= 1'b1;
        else        eoc_n_o <= !(done_a_o || done_b_o);
    end

    assign busy_o = (state_q != S_IDLE);

    always_comb begin
        unique case (state_q)
            S_CONV_A: late_half_o = (cnt_q >= A_HALF);
            S_CONV_B: late_half_o = (cnt_q >= B_HALF);
            default:  late_half_o = 1'b0;
        endcase
    end

    AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_n_o |=> eoc_n_o); // R4
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CONV_A) |-> (cnt_q <= A_LAST)); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CONV_A) && start_i && !done_a_o |=> (state_q == S_CONV_A)); // R3
endmodule

// File: rtl/dcr_results.sv
module dcr_results #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         launch_i,
    input  logic         done_a_i,
    input  logic         done_b_i,
    input  logic         serial_mode_i,
    input  logic [W-1:0] sample_a_i,
    input  logic [W-1:0] sample_b_i,
    output logic [W-1:0] res_a_o,
    output logic [W-1:0] res_b_o
);
    logic [W-1:0] pend_a_q, pend_b_q;

    // capture stimulus at the start of each channel's phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_a_q <= '0;
            pend_b_q <= '0;
        end else begin
            if (launch_i) pend_a_q <= sample_a_i;
            if (done_a_i) pend_b_q <= sample_b_i;
        end
    end

    // output registers with mode-dependent channel A update point
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_a_o <= '0;
            res_b_o <= '0;
        end else begin
            if (serial_mode_i ? done_b_i : done_a_i) res_a_o <= pend_a_q;
            if (done_b_i) res_b_o <= pend_b_q;
        end
    end

    AST_SERIAL_HOLDS_A: assert property (@(posedge clk) disable iff (!rst_n)
        serial_mode_i && done_a_i |=> $stable(res_a_o)); // R10
    AST_B_HELD_AT_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        done_a_i |=> $stable(res_b_o)); // R11
endmodule

// File: rtl/dcr_bus.sv
module dcr_bus #(
    parameter int W = 16
) (
    input  logic         cs_n_i,
    input  logic         rd_n_i,
    input  logic         chan_sel_i,
    input  logic         swap_i,
    input  logic         busy_i,
    input  logic         late_half_i,
    input  logic [W-1:0] res_a_i,
    input  logic [W-1:0] res_b_i,
    output logic [W-1:0] data_o,
    output logic         data_oe_o,
    output logic         late_read_o
);
    localparam int H = W / 2;

    logic [W-1:0] picked, laned;

    assign picked = chan_sel_i ? res_a_i : res_b_i;

    generate
        if (H * 2 == W) begin : g_even
            assign laned = swap_i ? {picked[H-1:0], picked[W-1:H]} : picked;
        end else begin : g_odd
            assign laned = picked;
        end
    endgenerate

    assign data_oe_o   = !cs_n_i && !rd_n_i;
    assign data_o      = data_oe_o ? laned : '0;
    assign late_read_o = data_oe_o && busy_i && late_half_i;

    always_comb begin
        if (!data_oe_o) AST_QUIET_BUS: assert (data_o == '0); // R8
    end
endmodule

// File: rtl/dualconv_read_if.sv
module dualconv_read_if #(
    parameter int DATA_W = 16,
    parameter int A_CYC  = 8,
    parameter int B_CYC  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] sample_a_i,
    input  logic [DATA_W-1:0] sample_b_i,
    input  logic              serial_mode_i,
    input  logic              cs_n_i,
    input  logic              rd_n_i,
    input  logic              chan_sel_i,
    input  logic              swap_i,
    output logic              busy_o,
    output logic              eoc_n_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              late_read_o
);
    logic launch, done_a, done_b, late_half;
    logic [DATA_W-1:0] res_a, res_b;

    dcr_seq #(.A_CYC(A_CYC), .B_CYC(B_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .launch_o(launch), .done_a_o(done_a), .done_b_o(done_b),
        .busy_o(busy_o), .eoc_n_o(eoc_n_o), .late_half_o(late_half)
    );

    dcr_results #(.W(DATA_W)) u_res (
        .clk(clk), .rst_n(rst_n), .launch_i(launch),
        .done_a_i(done_a), .done_b_i(done_b),
        .serial_mode_i(serial_mode_i),
        .sample_a_i(sample_a_i), .sample_b_i(sample_b_i),
        .res_a_o(res_a), .res_b_o(res_b)
    );

    dcr_bus #(.W(DATA_W)) u_bus (
        .cs_n_i(cs_n_i), .rd_n_i(rd_n_i), .chan_sel_i(chan_sel_i),
        .swap_i(swap_i), .busy_i(busy_o), .late_half_i(late_half),
        .res_a_i(res_a), .res_b_i(res_b),
        .data_o(data_o), .data_oe_o(data_oe_o), .late_read_o(late_read_o)
    );

    AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i || rd_n_i) |-> !data_oe_o); // R8
    AST_BUSY_FALL_EOC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !eoc_n_o); // R4
    AST_LATE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        late_read_o |-> (busy_o && data_oe_o)); // R12
endmodule

// File: tb/sim_dualconv_read_if.sv
module sim_dualconv_read_if;
    localparam int NA = 6;
    localparam int NB = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [15:0] sample_a_i = '0, sample_b_i = '0;
    logic serial_mode_i = 1'b0;
    logic cs_n_i = 1'b1, rd_n_i = 1'b1, chan_sel_i = 1'b1, swap_i = 1'b0;
    logic busy_o, eoc_n_o, data_oe_o, late_read_o;
    logic [15:0] data_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] old_a = '0, old_b = '0;

    always #2.5 clk = ~clk;

    dualconv_read_if #(.DATA_W(16), .A_CYC(NA), .B_CYC(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .sample_a_i(sample_a_i), .sample_b_i(sample_b_i),
        .serial_mode_i(serial_mode_i), .cs_n_i(cs_n_i), .rd_n_i(rd_n_i),
        .chan_sel_i(chan_sel_i), .swap_i(swap_i),
        .busy_o(busy_o), .eoc_n_o(eoc_n_o), .data_o(data_o),
        .data_oe_o(data_oe_o), .late_read_o(late_read_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic ch, input logic sw, output logic [15:0] v);
        chan_sel_i = ch; swap_i = sw; cs_n_i = 1'b0; rd_n_i = 1'b0;
        #0.5;
        v = data_o;
        cs_n_i = 1'b1; rd_n_i = 1'b1;
        #0.5;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        #1;
        chk("R1 busy", 16'(busy_o), 16'h0);
        chk("R1 eoc_n", 16'(eoc_n_o), 16'h1);
        chk("R1 oe", 16'(data_oe_o), 16'h0);
        chk("R1 late", 16'(late_read_o), 16'h0);
        rd(1'b1, 1'b0, v); chk("R1 res A", v, 16'h0);
        rd(1'b0, 1'b0, v); chk("R1 res B", v, 16'h0);
    endtask

    task automatic t_conv(input logic [15:0] va, input logic [15:0] vb, input logic ser);
        logic [15:0] v;
        @(negedge clk);
        serial_mode_i = ser; sample_a_i = va; sample_b_i = vb; start_i = 1'b1;
        @(posedge clk); #1;
        chk("R2 busy rises", 16'(busy_o), 16'h1);
        start_i = 1'b0; sample_a_i = ~va;           // R5 A already captured
        for (int i = 1; i < NA; i++) begin
            @(posedge clk); #1;
            chk("R4 eoc high in A", 16'(eoc_n_o), 16'h1);
        end
        @(posedge clk); #1;
        chk("R4 eoc low at handoff", 16'(eoc_n_o), 16'h0);
        chk("R2 busy in B", 16'(busy_o), 16'h1);
        sample_b_i = ~vb;                           // R5 B already captured
        rd(1'b1, 1'b0, v);
        if (ser) chk("R10 A held in serial", v, old_a);
        else     chk("R9 A early in parallel", v, va);
        rd(1'b0, 1'b0, v); chk("R11 B previous", v, old_b);
        for (int i = 1; i < NB; i++) begin
            @(posedge clk); #1;
            chk("R4 eoc high in B", 16'(eoc_n_o), 16'h1);
            chk("R2 busy held", 16'(busy_o), 16'h1);
        end
        @(posedge clk); #1;
        chk("R2 busy falls", 16'(busy_o), 16'h0);
        chk("R4 second eoc", 16'(eoc_n_o), 16'h0);
        rd(1'b1, 1'b0, v); chk("R5 A result", v, va);
        rd(1'b0, 1'b0, v); chk("R5 B result", v, vb);
        @(posedge clk); #1;
        chk("R4 eoc restores", 16'(eoc_n_o), 16'h1);
        old_a = va; old_b = vb;
    endtask

    task automatic t_ignore(input logic [15:0] va, input logic [15:0] vb);
        int len = 0;
        logic [15:0] v;
        @(negedge clk);
        serial_mode_i = 1'b0; sample_a_i = va; sample_b_i = vb; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        while (busy_o && len < 100) begin
            len++;
            if (len == 3 || len == NA + 2) start_i = 1'b1;
            else start_i = 1'b0;
            sample_a_i = 16'hDEAD;
            @(posedge clk); #1;
        end
        start_i = 1'b0;
        chk("R3 cycle length", 16'(len), 16'(NA + NB));
        repeat (4) @(posedge clk);
        #1;
        chk("R3 no second cycle", 16'(busy_o), 16'h0);
        rd(1'b1, 1'b0, v); chk("R3 A unaffected", v, va);
        rd(1'b0, 1'b0, v); chk("R3 B unaffected", v, vb);
        old_a = va; old_b = vb;
    endtask

    task automatic t_lanes;
        logic [15:0] v;
        @(negedge clk);
        rd(1'b1, 1'b0, v); chk("R6 select A", v, old_a);
        rd(1'b0, 1'b0, v); chk("R6 select B", v, old_b);
        rd(1'b1, 1'b1, v); chk("R7 swap A", v, {old_a[7:0], old_a[15:8]});
        rd(1'b0, 1'b1, v); chk("R7 swap B", v, {old_b[7:0], old_b[15:8]});
        cs_n_i = 1'b0; rd_n_i = 1'b1; #0.5;
        chk("R8 rd high oe", 16'(data_oe_o), 16'h0);
        chk("R8 rd high data", data_o, 16'h0);
        cs_n_i = 1'b1; rd_n_i = 1'b0; #0.5;
        chk("R8 cs high oe", 16'(data_oe_o), 16'h0);
        cs_n_i = 1'b0; #0.5;
        chk("R8 both low oe", 16'(data_oe_o), 16'h1);
        cs_n_i = 1'b1; rd_n_i = 1'b1; #0.5;
    endtask

    task automatic t_late;
        @(negedge clk);
        sample_a_i = 16'h0101; sample_b_i = 16'h0202; start_i = 1'b1;
        cs_n_i = 1'b0; rd_n_i = 1'b0;
        #0.5;
        chk("R12 idle read", 16'(late_read_o), 16'h0);
        for (int i = 0; i < NA; i++) begin
            @(posedge clk); #1;
            start_i = 1'b0;
            chk("R12 phase A", 16'(late_read_o), 16'(i >= NA / 2));
        end
        for (int j = 0; j < NB; j++) begin
            @(posedge clk); #1;
            chk("R12 phase B", 16'(late_read_o), 16'(j >= NB / 2));
        end
        @(posedge clk); #1;
        chk("R12 after cycle", 16'(late_read_o), 16'h0);
        cs_n_i = 1'b1; rd_n_i = 1'b1;
        old_a = 16'h0101; old_b = 16'h0202;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #12 rst_n = 1'b1;
        t_reset();
        t_conv(16'hA15C, 16'h3B7E, 1'b0);
        t_conv(16'h5A0F, 16'hC3D2, 1'b1);
        t_conv(16'h1234, 16'h8765, 1'b0);
        t_ignore(16'h4E21, 16'h9F80);
        t_lanes();
        t_late();
        t_lanes();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule